// File: doc/BRIEF.md
# Byte-wide SPI controller with buffered transmit

This block is an SPI peripheral that can act as either the clock-driving end (master) or the clock-following end (slave) of a byte-wide link. Software talks to it through a small register bus with three registers: data, control and status. A byte written to the data register waits in a single-entry transmit buffer. It moves into the shift register when a transfer starts. In master mode the block drives SCK from a programmable divider. The divider's base clock is either the system clock or a pulse from an external timer. The block shifts MSB first in SPI mode 0. It raises one interrupt line for transfer completion, mode fault and, optionally, transmit-buffer-empty.

Register map (bus_sel): 0 = data (a write fills the transmit buffer, a read returns the last received byte), 1 = control, 2 = status. Control layout: bit 0 enable, bit 1 master, bits 3:2 rate code, bit 4 clock source (0 = system clock, 1 = timer pulse). Status layout: bit 7 transfer done, bit 6 write collision, bit 5 mode fault, bit 4 buffer empty, bit 3 reads 0, bit 2 ignore-SS, bit 1 slave-output disable, bit 0 enhanced interrupt enable.

The transfer engine is a state machine with three states. ST_IDLE: no transfer in progress. ST_LEAD: SCK is low and the next bit is being presented. ST_TRAIL: SCK is high and the sampled bit waits to be shifted in. The transitions are:
- start, ST_IDLE to ST_LEAD: in master mode this needs a buffered byte; in slave mode it needs SS low.
- sample, ST_LEAD to ST_TRAIL: taken on a divider tick in master mode, or on a synchronized SCK rise in slave mode.
- shift, ST_TRAIL to ST_LEAD: taken on a divider tick or a synchronized SCK fall while bits remain.
- finish, ST_TRAIL to ST_IDLE: the eighth shift.
- abort, ST_LEAD or ST_TRAIL to ST_IDLE: taken when the block is disabled, the mode bit changes, or SS rises in slave mode.

Top module: `spi_ctl`

## Requirements
- R1: In master mode the SCK period equals 4, 8, 32 or 64 base ticks for rate code 0, 1, 2 or 3 (control bits 3:2). The base tick is every system clock when control bit 4 is 0 and each tmr_ovf pulse when it is 1.
- R2: A master transfer shifts the 8 bits of the buffered byte out on mosi_out MSB first, stable across each SCK rise. It samples miso_in on each SCK rise and makes the received byte readable at data address 0.
- R3: Status bit 7 (done) is set when the eighth bit has been shifted, in both master and slave mode.
- R4: Writing 0 to status bit 7, 6, 5 or 4 clears that flag, and writing 1 leaves it unchanged. A status read followed by a data read or write clears bits 7 and 6.
- R5: A data write while the transmit buffer is full sets status bit 6 and discards the byte. The transfer in progress and the byte already buffered are unaffected.
- R6: Status bit 4 (buffer empty) is set when the buffered byte moves into the shift register. Only a software write clears it.
- R7: When control bits 0 and 1 are set, status bit 2 is 0 and the 2-flop-synchronized SS is low, status bit 5 is set. Control bit 1 is cleared and sck_oe and mosi_oe fall on the same clock edge.
- R8: With status bit 2 (ignore-SS) set, SS low in master mode causes no mode fault and leaves the master bit set.
- R9: irq equals irq_en AND (done OR mode fault OR (status bit 0 AND buffer empty)).
- R10: In slave mode (control bit 0 set, bit 1 clear) a transfer starts when SS goes low. The block samples mosi_in on SCK rise, shifts on SCK fall, and drives miso_out MSB first.
- R11: A slave that has no new byte buffered before its next transfer shifts out the byte it last received.
- R12: miso_oe is 1 only when the block is an enabled slave, the synchronized SS is low and status bit 1 is 0.
- R13: After reset the control and status registers read 0, sck_oe, mosi_oe, miso_oe and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select: 0 data, 1 control, 2 status |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected register |
| irq_en | input | 1 | Interrupt enable |
| tmr_ovf | input | 1 | Timer overflow pulse, alternative base clock |
| ss_n_in | input | 1 | Slave-select input, active low |
| sck_in | input | 1 | SCK from an external master |
| mosi_in | input | 1 | Serial data in, slave mode |
| miso_in | input | 1 | Serial data in, master mode |
| sck_out | output | 1 | SCK driven in master mode |
| sck_oe | output | 1 | SCK driver enable |
| mosi_out | output | 1 | Serial data out, master mode |
| mosi_oe | output | 1 | MOSI driver enable |
| miso_out | output | 1 | Serial data out, slave mode |
| miso_oe | output | 1 | MISO driver enable |
| irq | output | 1 | Interrupt request |

## Verification
Master transfers are exercised with a table of bytes whose bit patterns are alternating, all-ones, all-zeros and single-bit. This separates a bit-order or off-by-one shift fault from a stuck line. Each table row uses a different rate code and clock source, so a divider that picks the wrong divisor or ignores the timer pulse shows up as a wrong SCK period. A burst of three data writes tells the buffered byte apart from the discarded one. Two back-to-back slave bytes, the second with no new data loaded, separate a fresh load from the echo of the received byte.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } xfer_state_t;

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CTL  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

    // Half of the SCK period in base ticks for each rate code.
    function automatic int unsigned half_period(input logic [1:0] code);
        int unsigned base;
        base = code[1] ? 16 : 2;
        return code[0] ? (base * 2) : base;
    endfunction

endpackage

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
    parameter int unsigned   W   = 1,
    parameter logic [W-1:0]  RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST;
            q      <= RST;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/spi_ctl_clkdiv.sv
module spi_ctl_clkdiv
    import spi_ctl_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       src_tmr,
    input  logic       tmr_ovf,
    input  logic [1:0] rate,
    output logic       tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             base;

    assign base = src_tmr ? tmr_ovf : 1'b1;
    assign last = CNT_W'(half_period(rate) - 1);
    assign tick = run && base && (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (base) begin
            cnt_q <= (cnt_q == last) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // Two edges of SCK are never one clock apart (half period >= 2).
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/spi_ctl_engine.sv
module spi_ctl_engine
    import spi_ctl_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         master,
    input  logic         tx_full,
    input  logic [W-1:0] tx_byte,
    input  logic         tick,
    input  logic         ss_s,
    input  logic         sck_rise,
    input  logic         sck_fall,
    input  logic         mosi_s,
    input  logic         miso_in,
    output logic         load,
    output logic         done,
    output logic [W-1:0] rx_byte,
    output logic         sck_out,
    output logic         out_bit,
    output logic         run_mst
);

    localparam int unsigned   CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    xfer_state_t   st_q, st_d;
    logic          is_mst;
    logic [CW-1:0] bit_q;
    logic [W-1:0]  sh_q;
    logic          samp_q;
    logic          start_m, start_s, start;
    logic          abort, adv_lead, adv_trail, shift_ev, last_bit;

    assign start_m   = enable && master && tx_full;
    assign start_s   = enable && !master && !ss_s;
    assign start     = start_m || start_s;
    assign abort     = !enable || (is_mst != master) || (!is_mst && ss_s);
    assign adv_lead  = is_mst ? tick : sck_rise;
    assign adv_trail = is_mst ? tick : sck_fall;
    assign last_bit  = (bit_q == LAST);
    assign shift_ev  = (st_q == ST_TRAIL) && !abort && adv_trail;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) st_d = ST_LEAD;
            end
            ST_LEAD: begin
                if (abort)         st_d = ST_IDLE;
                else if (adv_lead) st_d = ST_TRAIL;
            end
            ST_TRAIL: begin
                if (abort)          st_d = ST_IDLE;
                else if (adv_trail) st_d = last_bit ? ST_IDLE : ST_LEAD;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_mst <= 1'b0;
            bit_q  <= '0;
            sh_q   <= '0;
            samp_q <= 1'b0;
        end else begin
            if (st_q == ST_IDLE && start) begin
                is_mst <= master;
                bit_q  <= '0;
                if (tx_full) sh_q <= tx_byte;
            end
            if (st_q == ST_LEAD && !abort && adv_lead)
                samp_q <= is_mst ? miso_in : mosi_s;
            if (shift_ev) begin
                sh_q  <= {sh_q[W-2:0], samp_q};
                bit_q <= bit_q + CW'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        load    = (st_q == ST_IDLE) && start && tx_full;
        done    = shift_ev && last_bit;
        rx_byte = {sh_q[W-2:0], samp_q};
        sck_out = (st_q == ST_TRAIL) && is_mst;
        out_bit = sh_q[W-1];
        run_mst = (st_q != ST_IDLE) && is_mst;
    end

    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (st_q == ST_IDLE));

    p_sck_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mst && !tick && !abort) |=> $stable(sck_out));

endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
    import spi_ctl_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_en,
    input  logic              tmr_ovf,
    input  logic              ss_n_in,
    input  logic              sck_in,
    input  logic              mosi_in,
    input  logic              miso_in,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              mosi_out,
    output logic              mosi_oe,
    output logic              miso_out,
    output logic              miso_oe,
    output logic              irq
);

    localparam int unsigned SYNC_W = 3;

    // Control fields
    logic              c_en, c_mst, c_src;
    logic [1:0]        c_rate;
    // Status flags and settings
    logic              f_done, f_wcol, f_mflt, f_txe;
    logic              s_ign, s_sodis, s_enh;
    // Transmit buffer and received byte
    logic [DATA_W-1:0] tx_buf, rx_q;
    logic              tx_full;
    logic              arm_q;

    logic [SYNC_W-1:0] sync_q;
    logic              ss_s, sck_s, mosi_s, sck_d;
    logic              wr_data, wr_ctl, wr_stat, rd_data, rd_stat;
    logic              acc_clr, fault, wcol_set;
    logic              eng_load, eng_done, eng_tick, eng_run, eng_bit;
    logic [DATA_W-1:0] eng_rx;

    assign wr_data = bus_wr && (bus_sel == A_DATA);
    assign wr_ctl  = bus_wr && (bus_sel == A_CTL);
    assign wr_stat = bus_wr && (bus_sel == A_STAT);
    assign rd_data = bus_rd && (bus_sel == A_DATA);
    assign rd_stat = bus_rd && (bus_sel == A_STAT);

    spi_ctl_sync #(.W(SYNC_W), .RST(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n_in, sck_in, mosi_in}),
        .q     (sync_q)
    );
    assign {ss_s, sck_s, mosi_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    spi_ctl_clkdiv #(.CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (eng_run),
        .src_tmr (c_src),
        .tmr_ovf (tmr_ovf),
        .rate    (c_rate),
        .tick    (eng_tick)
    );

    spi_ctl_engine #(.W(DATA_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (c_en),
        .master   (c_mst),
        .tx_full  (tx_full),
        .tx_byte  (tx_buf),
        .tick     (eng_tick),
        .ss_s     (ss_s),
        .sck_rise (sck_s && !sck_d),
        .sck_fall (!sck_s && sck_d),
        .mosi_s   (mosi_s),
        .miso_in  (miso_in),
        .load     (eng_load),
        .done     (eng_done),
        .rx_byte  (eng_rx),
        .sck_out  (sck_out),
        .out_bit  (eng_bit),
        .run_mst  (eng_run)
    );

    assign fault    = c_en && c_mst && !s_ign && !ss_s;
    assign acc_clr  = arm_q && (rd_data || wr_data);
    assign wcol_set = wr_data && tx_full;

    // Control register; a mode fault drops the master bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_en   <= 1'b0;
            c_mst  <= 1'b0;
            c_rate <= 2'b00;
            c_src  <= 1'b0;
        end else begin
            if (wr_ctl) begin
                c_en   <= bus_wdata[0];
                c_mst  <= bus_wdata[1];
                c_rate <= bus_wdata[3:2];
                c_src  <= bus_wdata[4];
            end
            if (fault) c_mst <= 1'b0;
        end
    end

    // Status flags: hardware set wins over any clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_done  <= 1'b0;
            f_wcol  <= 1'b0;
            f_mflt  <= 1'b0;
            f_txe   <= 1'b0;
            s_ign   <= 1'b0;
            s_sodis <= 1'b0;
            s_enh   <= 1'b0;
            arm_q   <= 1'b0;
        end else begin
            if (eng_done)                                  f_done <= 1'b1;
            else if ((wr_stat && !bus_wdata[7]) || acc_clr) f_done <= 1'b0;

            if (wcol_set)                                  f_wcol <= 1'b1;
            else if ((wr_stat && !bus_wdata[6]) || acc_clr) f_wcol <= 1'b0;

            if (fault)                         f_mflt <= 1'b1;
            else if (wr_stat && !bus_wdata[5]) f_mflt <= 1'b0;

            if (eng_load)                      f_txe <= 1'b1;
            else if (wr_stat && !bus_wdata[4]) f_txe <= 1'b0;

            if (wr_stat) begin
                s_ign   <= bus_wdata[2];
                s_sodis <= bus_wdata[1];
                s_enh   <= bus_wdata[0];
            end

            if (rd_stat)                 arm_q <= 1'b1;
            else if (rd_data || wr_data) arm_q <= 1'b0;
        end
    end

    // Transmit buffer and receive holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            tx_full <= 1'b0;
            rx_q    <= '0;
        end else begin
            if (wr_data && !tx_full) begin
                tx_buf  <= bus_wdata;
                tx_full <= 1'b1;
            end else if (eng_load) begin
                tx_full <= 1'b0;
            end
            if (eng_done) rx_q <= eng_rx;
        end
    end

    always_comb begin
        unique case (bus_sel)
            A_DATA:  bus_rdata = rx_q;
            A_CTL:   bus_rdata = DATA_W'({c_src, c_rate, c_mst, c_en});
            A_STAT:  bus_rdata = DATA_W'({f_done, f_wcol, f_mflt, f_txe,
                                          1'b0, s_ign, s_sodis, s_enh});
            default: bus_rdata = '0;
        endcase
    end

    assign sck_oe   = c_en && c_mst;
    assign mosi_oe  = c_en && c_mst;
    assign mosi_out = eng_bit;
    assign miso_out = eng_bit;
    assign miso_oe  = c_en && !c_mst && !ss_s && !s_sodis;
    assign irq      = irq_en && (f_done || f_mflt || (s_enh && f_txe));

    p_wcol_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && tx_full) |=> ($stable(tx_buf) && f_wcol));

    p_txe_on_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_load |=> f_txe);

    p_fault_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (f_mflt && !sck_oe && !mosi_oe));

    p_ign_no_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ign && !f_mflt) |=> !f_mflt);

endmodule

// File: tb/spi_ctl_tb.sv
module spi_ctl_tb;
    import spi_ctl_pkg::*;

    localparam int CLK_P = 10;
    localparam int NVEC  = 6;
    // {src, rate, tx byte, slave reply byte, expected SCK period in clocks}
    localparam logic [34:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 8'hA5, 8'h3C, 16'd4},
        {1'b0, 2'd1, 8'h5A, 8'hC3, 16'd8},
        {1'b0, 2'd2, 8'h81, 8'h7E, 16'd32},
        {1'b0, 2'd3, 8'hFF, 8'h00, 16'd64},
        {1'b1, 2'd0, 8'h12, 8'hE7, 16'd12},
        {1'b1, 2'd1, 8'h00, 8'hFF, 16'd24}
    };

    logic       clk, rst_n;
    logic [1:0] bus_sel;
    logic       bus_wr, bus_rd;
    logic [7:0] bus_wdata, bus_rdata;
    logic       irq_en, tmr_ovf, ss_n_in, sck_in, mosi_in, miso_in;
    logic       sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe, irq;

    int   n_chk, n_fail;
    logic [7:0] cap, sl_sh, sl_val;
    logic sl_load;
    time  t_a, t_b;

    spi_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_en(irq_en), .tmr_ovf(tmr_ovf), .ss_n_in(ss_n_in),
        .sck_in(sck_in), .mosi_in(mosi_in), .miso_in(miso_in),
        .sck_out(sck_out), .sck_oe(sck_oe), .mosi_out(mosi_out),
        .mosi_oe(mosi_oe), .miso_out(miso_out), .miso_oe(miso_oe), .irq(irq)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_P / 2) clk = ~clk;
    end

    initial begin
        int tc;
        tc = 0;
        tmr_ovf = 1'b0;
        forever begin
            @(negedge clk);
            tmr_ovf = (tc == 2);
            tc = (tc + 1) % 3;
        end
    end

    // Bench slave model on the master-side pins
    assign miso_in = sl_sh[7];
    always @(negedge sck_out or posedge sl_load) begin
        if (sl_load) sl_sh <= sl_val;
        else         sl_sh <= {sl_sh[6:0], 1'b0};
    end
    always @(posedge sck_out) begin
        cap <= {cap[6:0], mosi_out};
        t_a = t_b;
        t_b = $time;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_sel = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_sel = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_done(output logic ok);
        logic [7:0] v;
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            rd(A_STAT, v);
            if (v[7]) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic load_slave(input logic [7:0] v);
        sl_val = v; sl_load = 1'b1;
        #1 sl_load = 1'b0;
    endtask

    // Bench acts as an external master; returns what the DUT shifted out.
    task automatic slave_xfer(input logic [7:0] m, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            mosi_in = m[i];
            tk(8);
            sck_in = 1'b1;
            got[i] = miso_out;
            tk(8);
            sck_in = 1'b0;
        end
        tk(8);
    endtask

    task automatic finish_up;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [7:0] v, got;
        logic       ok;
        n_chk = 0; n_fail = 0;
        rst_n = 1'b0; bus_sel = 2'd0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_wdata = 8'h00; irq_en = 1'b0; ss_n_in = 1'b1;
        sck_in = 1'b0; mosi_in = 1'b0; sl_load = 1'b0; sl_val = 8'h00;
        cap = 8'h00; t_a = 0; t_b = 0;
        tk(3);
        rst_n = 1'b1;
        tk(2);

        // R13 reset state
        rd(A_STAT, v); chk("R13 status after reset", v, 8'h00);
        rd(A_CTL, v);  chk("R13 control after reset", v, 8'h00);
        chk("R13 oe and irq after reset", {sck_oe, mosi_oe, miso_oe, irq}, 4'b0000);

        // Table of master transfers: R1 R2 R3 R6 R4
        for (int k = 0; k < NVEC; k++) begin
            wr(A_CTL, {3'b000, VEC[k][34], VEC[k][33:32], 2'b11});
            wr(A_STAT, 8'h00);
            load_slave(VEC[k][23:16]);
            wr(A_DATA, VEC[k][31:24]);
            wait_done(ok);
            chk("R3 done flag after master byte", ok, 1'b1);
            rd(A_STAT, v);
            chk("R6 buffer empty after load", v[4], 1'b1);
            rd(A_DATA, v);
            chk("R2 received byte", v, VEC[k][23:16]);
            chk("R2 MOSI byte MSB first", cap, VEC[k][31:24]);
            chk("R1 SCK period", 32'((t_b - t_a) / CLK_P), 32'(VEC[k][15:0]));
            rd(A_STAT, v);
            chk("R4 status read then data read clears done/wcol", v[7:6], 2'b00);
        end

        // R5 write collision while the buffer is full
        wr(A_CTL, 8'h0F);
        wr(A_STAT, 8'h00);
        load_slave(8'h00);
        wr(A_DATA, 8'hC9);
        tk(2);
        wr(A_DATA, 8'h36);
        wr(A_DATA, 8'h0F);
        rd(A_STAT, v);
        chk("R5 collision flag set", v[6], 1'b1);
        wait_done(ok);
        chk("R5 ongoing byte unaffected", cap, 8'hC9);
        rd(A_STAT, v);
        chk("R6 buffer empty stays set until written 0", v[4], 1'b1);
        wr(A_STAT, 8'h10);
        rd(A_STAT, v);
        chk("R4 write 0 clears done and collision, 1 keeps empty", v[7:4], 4'b0001);
        wait_done(ok);
        chk("R5 buffered byte sent, colliding byte discarded", cap, 8'h36);

        // R9 interrupt combination
        wr(A_STAT, 8'h10);
        irq_en = 1'b1;
        tk(1);
        chk("R9 empty flag without enhanced bit raises no irq", irq, 1'b0);
        wr(A_STAT, 8'h11);
        chk("R9 empty flag with enhanced bit raises irq", irq, 1'b1);
        irq_en = 1'b0;
        tk(1);
        chk("R9 irq gated by irq_en", irq, 1'b0);
        wr(A_STAT, 8'h00);
        wr(A_STAT, 8'hF0);
        rd(A_STAT, v);
        chk("R4 writing 1 sets no flag", v, 8'h00);

        // R7 mode fault
        wr(A_CTL, 8'h03);
        irq_en = 1'b1;
        chk("R7 drivers on before fault", {sck_oe, mosi_oe}, 2'b11);
        ss_n_in = 1'b0;
        tk(4);
        rd(A_STAT, v);
        chk("R7 mode fault flag", v[5], 1'b1);
        rd(A_CTL, v);
        chk("R7 master bit cleared", v[1], 1'b0);
        chk("R7 drivers released", {sck_oe, mosi_oe}, 2'b00);
        chk("R9 irq on mode fault", irq, 1'b1);
        ss_n_in = 1'b1;
        tk(4);
        rd(A_STAT, v);
        rd(A_DATA, v);
        rd(A_STAT, v);
        chk("R7 fault not cleared by status/data access", v[5], 1'b1);
        wr(A_STAT, 8'h00);
        rd(A_STAT, v);
        chk("R7 fault cleared by write 0", v[5], 1'b0);
        irq_en = 1'b0;

        // R8 ignore-SS
        wr(A_STAT, 8'h04);
        wr(A_CTL, 8'h03);
        ss_n_in = 1'b0;
        tk(5);
        rd(A_STAT, v);
        chk("R8 no fault with ignore-SS", v[5], 1'b0);
        rd(A_CTL, v);
        chk("R8 master bit kept", v[1], 1'b1);
        chk("R8 SCK driver kept", sck_oe, 1'b1);
        ss_n_in = 1'b1;
        tk(4);

        // Slave mode: R10 R11 R12
        wr(A_CTL, 8'h01);
        wr(A_STAT, 8'h00);
        wr(A_DATA, 8'h96);
        tk(4);
        chk("R12 MISO off while SS high", miso_oe, 1'b0);
        ss_n_in = 1'b0;
        tk(8);
        chk("R12 MISO on for selected slave", miso_oe, 1'b1);
        rd(A_STAT, v);
        chk("R6 buffer empty on slave load", v[4], 1'b1);
        slave_xfer(8'h3B, got);
        chk("R10 slave shifts buffered byte", got, 8'h96);
        rd(A_STAT, v);
        chk("R3 done after slave byte", v[7], 1'b1);
        rd(A_DATA, v);
        chk("R10 slave received byte", v, 8'h3B);
        slave_xfer(8'h44, got);
        chk("R11 slave echoes last received byte", got, 8'h3B);
        rd(A_DATA, v);
        chk("R10 second slave byte received", v, 8'h44);
        wr(A_STAT, 8'h02);
        chk("R12 MISO off with output disable", miso_oe, 1'b0);
        ss_n_in = 1'b1;
        tk(4);

        finish_up();
    end

endmodule